// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Each clock it receives a small count of events from an upstream selector, together with the privilege ring the processor is running in. A configuration word decides what is counted. The choices are the raw number of events, the cycles whose event count meets a threshold, the cycles whose count falls below it, or only the rising edges of that threshold condition. A ring filter admits kernel-level activity, user-level activity or both.

Software reads and writes the 48-bit count through a plain register port. When the count wraps past its maximum and interrupts are enabled, a sticky status bit is set and an interrupt line is driven until software clears it. Each counter stands alone and never carries into a neighbour.

Top module: `qual_event_counter`

## Requirements
- R1: While `rst` is high and after it, `cnt_value` is 0, `ovf_status` is 0, `irq` is 0 and the stored configuration is all zeros, so the counter is disabled.
- R2: A pulse on `cfg_we` stores `cfg_wdata` and the new setting governs counting from the following cycle. Field layout: bits [7:0] threshold, bit 8 invert, bit 9 edge mode, bit 10 user enable, bit 11 kernel enable, bit 12 interrupt enable, bit 13 global enable.
- R3: With threshold 0, each enabled and admitted cycle adds the full value of `evt_count` (0 to 15) to the counter.
- R4: With a nonzero threshold and invert clear, the counter gains exactly 1 in each admitted cycle where `evt_count` is at or above the threshold, and 0 otherwise.
- R5: With a nonzero threshold and invert set, the counter gains 1 in each admitted cycle where `evt_count` is below the threshold.
- R6: With a nonzero threshold and edge mode set, the counter gains 1 only on a cycle where the threshold condition is true and was false in the previous enabled cycle. Threshold 1 with edge mode therefore counts separate bursts of activity.
- R7: Ring 0 (`priv_level` = 0) is admitted only by the kernel enable, and rings 1 to 3 only by the user enable. A cycle that is not admitted adds nothing.
- R8: When both the user enable and the kernel enable are clear, every ring is admitted.
- R9: While the global enable is 0 the counter holds its value. The edge history is cleared on every configuration write and while the counter is disabled, so a condition that is already true when counting resumes counts as one rising edge.
- R10: A write on `cnt_we` loads `cnt_wdata` and overrides any increment in the same cycle.
- R11: The counter wraps modulo 2^48. A wrap with interrupt enable set makes `ovf_status` and `irq` 1, and they stay 1 until an `ovf_clr` pulse. A wrap with interrupt enable clear leaves them at 0.
- R12: With threshold 0, the invert and edge flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration word (layout in R2) |
| evt_count | input | 4 | Number of events reported this cycle |
| priv_level | input | 2 | Current privilege ring, 0 = kernel |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 48 | Value loaded into the counter |
| ovf_clr | input | 1 | Clears the overflow status |
| cnt_value | output | 48 | Current counter value |
| ovf_status | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
An event applied in cycle N shows up in `cnt_value` after the clock edge that ends N, so it is one register away. A configuration written in cycle N first qualifies the events of cycle N+1, and its effect shows after the edge that ends N+1. A counter write and a wrap-induced `ovf_status` each appear one edge after their cycle. Every scenario drives inputs just after a falling edge, lets one rising edge pass, and samples on the next falling edge. Edge-mode tests hold the condition true across configuration writes so that the history-clearing cycle is exercised.

// File: rtl/pevc_pkg.sv
package pevc_pkg;

    localparam int CNT_W = 48;
    localparam int EVT_W = 4;
    localparam int THR_W = 8;
    localparam int CFG_W = THR_W + 6;
    localparam int PRV_W = 2;

    // Packed MSB first: enable is the top bit, threshold the low byte.
    typedef struct packed {
        logic             enable;
        logic             irq_en;
        logic             krn_en;
        logic             usr_en;
        logic             edge_mode;
        logic             invert;
        logic [THR_W-1:0] thresh;
    } cfg_t;

    typedef enum logic [PRV_W-1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_ONE    = 2'd1,
        PRIV_TWO    = 2'd2,
        PRIV_THREE  = 2'd3
    } priv_e;

    // Ring filter: no enable set at all means admit everything.
    function automatic logic ring_admitted(cfg_t c, priv_e lvl);
        if (!c.usr_en && !c.krn_en)
            return 1'b1;
        return (lvl == PRIV_KERNEL) ? c.krn_en : c.usr_en;
    endfunction

    // Threshold compare, optionally inverted.
    function automatic logic thresh_hit(cfg_t c, logic [EVT_W-1:0] n);
        logic ge;
        ge = ({{(THR_W-EVT_W){1'b0}}, n} >= c.thresh);
        return c.invert ? !ge : ge;
    endfunction

endpackage

// File: rtl/pevc_qualify.sv
module pevc_qualify
    import pevc_pkg::*;
#(
    parameter int EW = EVT_W
) (
    input  cfg_t          cfg_i,
    input  logic [EW-1:0] evt_i,
    input  priv_e         priv_i,
    output logic [EW-1:0] raw_o,
    output logic          cond_o,
    output logic          thr_mode_o
);
    logic admit;

    always_comb begin
        admit      = ring_admitted(cfg_i, priv_i);
        thr_mode_o = (cfg_i.thresh != '0);
        raw_o      = admit ? evt_i : '0;
        cond_o     = admit && thr_mode_o && thresh_hit(cfg_i, evt_i);
    end

endmodule

// File: rtl/pevc_edge.sv
module pevc_edge (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic track_i,
    input  logic cond_i,
    output logic pulse_o
);
    logic hist_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i || !track_i)
            hist_q <= 1'b0;
        else
            hist_q <= cond_i;
    end

    assign pulse_o = cond_i && !hist_q;

    // R6: a held condition produces no second pulse.
    p_edge_once_r6: assert property (@(posedge clk) disable iff (rst)
        (track_i && cond_i && !clear_i) |=> !pulse_o);

endmodule

// File: rtl/pevc_accum.sv
module pevc_accum
    import pevc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int EW = EVT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [EW-1:0] inc_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          irq_en_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);
    localparam int SUM_W = CW + 1;

    logic [CW-1:0]  cnt_q;
    logic           ovf_q;
    logic [SUM_W-1:0] sum;
    logic           wrap;

    always_comb begin
        sum  = {1'b0, cnt_q} + {{(SUM_W-EW){1'b0}}, inc_i};
        wrap = en_i && !wr_i && sum[CW];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (wr_i)
            cnt_q <= wdata_i;
        else if (en_i)
            cnt_q <= sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (wrap && irq_en_i)
            ovf_q <= 1'b1;
        else if (clr_i)
            ovf_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R9: disabled and unwritten means no change.
    p_hold_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !wr_i) |=> (cnt_q == $past(cnt_q)));

    // R10: a software write lands regardless of increments.
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (cnt_q == $past(wdata_i)));

    // R3: one cycle never advances the count by more than the input range.
    p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && !wr_i) |=> ((cnt_q - $past(cnt_q)) <= CW'((1 << EW) - 1)));

    // R11: the sticky flag only drops after a clear request.
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_q) |-> $past(clr_i));

endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import pevc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [EVT_W-1:0] evt_count,
    input  logic [PRV_W-1:0] priv_level,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_value,
    output logic             ovf_status,
    output logic             irq
);
    cfg_t             cfg_q;
    logic [EVT_W-1:0] raw_cnt;
    logic             cond;
    logic             thr_mode;
    logic             pulse;
    logic             unit_hit;
    logic [EVT_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_t'(cfg_wdata);
    end

    pevc_qualify #(.EW(EVT_W)) u_qual (
        .cfg_i      (cfg_q),
        .evt_i      (evt_count),
        .priv_i     (priv_e'(priv_level)),
        .raw_o      (raw_cnt),
        .cond_o     (cond),
        .thr_mode_o (thr_mode)
    );

    pevc_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cfg_we),
        .track_i (cfg_q.enable),
        .cond_i  (cond),
        .pulse_o (pulse)
    );

    always_comb begin
        unit_hit = cfg_q.edge_mode ? pulse : cond;
        step     = thr_mode ? {{(EVT_W-1){1'b0}}, unit_hit} : raw_cnt;
    end

    pevc_accum #(.CW(CNT_W), .EW(EVT_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en_i     (cfg_q.enable),
        .inc_i    (step),
        .wr_i     (cnt_we),
        .wdata_i  (cnt_wdata),
        .irq_en_i (cfg_q.irq_en),
        .clr_i    (ovf_clr),
        .cnt_o    (cnt_value),
        .ovf_o    (ovf_status)
    );

    assign irq = ovf_status;

    // R7: ring 0 with only user counting enabled adds nothing.
    p_ring_block_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.usr_en && !cfg_q.krn_en && priv_level == 2'd0 && !cnt_we && !cfg_we)
        |=> (cnt_value == $past(cnt_value)));

    // R4: threshold mode advances by at most one per cycle.
    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.enable && cfg_q.thresh != '0 && !cnt_we)
        |=> ((cnt_value - $past(cnt_value)) <= CNT_W'(1)));

endmodule

// File: tb/sim_qual_event_counter.sv
`timescale 1ns/1ps
module sim_qual_event_counter;
    import pevc_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_we;
    logic [CFG_W-1:0] cfg_wdata;
    logic [EVT_W-1:0] evt_count;
    logic [PRV_W-1:0] priv_level;
    logic             cnt_we;
    logic [CNT_W-1:0] cnt_wdata;
    logic             ovf_clr;
    logic [CNT_W-1:0] cnt_value;
    logic             ovf_status;
    logic             irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    qual_event_counter u0 (.*);

    task automatic chk(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // thr, inv, edge, usr, krn, irq_en, en
    task automatic set_cfg(int thr, bit inv, bit edg, bit usr, bit krn, bit ie, bit en);
        cfg_wdata = {en, ie, krn, usr, edg, inv, 8'(thr)};
        cfg_we    = 1'b1;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic load_cnt(logic [CNT_W-1:0] v);
        cnt_wdata = v;
        cnt_we    = 1'b1;
        tick();
        cnt_we    = 1'b0;
    endtask

    task automatic step(int n, int ring);
        evt_count  = 4'(n);
        priv_level = 2'(ring);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 count", cnt_value, 0);
        chk("R1 status", {47'd0, ovf_status}, 0);
        chk("R1 irq", {47'd0, irq}, 0);
        step(9, 0);
        chk("R1 disabled after reset", cnt_value, 0);
    endtask

    task automatic t_raw();
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 1, 0, 1);
        load_cnt(0);
        step(3, 3); step(15, 3); step(0, 3); step(7, 1);
        chk("R3 R2 raw sum", cnt_value, 25);
    endtask

    task automatic t_thresh();
        evt_count = 0;
        set_cfg(4, 0, 0, 1, 1, 0, 1);
        load_cnt(0);
        step(3, 2); step(4, 2); step(9, 2); step(15, 2); step(0, 2);
        chk("R4 at or above", cnt_value, 3);
    endtask

    task automatic t_invert();
        evt_count = 0;
        set_cfg(4, 1, 0, 1, 1, 0, 1);
        load_cnt(0);
        step(3, 2); step(4, 2); step(9, 2); step(15, 2); step(0, 2);
        chk("R5 below", cnt_value, 2);
    endtask

    task automatic t_edge();
        evt_count = 0;
        set_cfg(1, 0, 1, 1, 1, 0, 1);
        load_cnt(0);
        step(2, 1); step(2, 1); step(2, 1); step(0, 1);
        step(1, 1); step(1, 1); step(0, 1); step(5, 1);
        chk("R6 bursts", cnt_value, 3);
    endtask

    task automatic t_no_thresh_flags();
        evt_count = 0;
        set_cfg(0, 1, 1, 1, 1, 0, 1);
        load_cnt(0);
        step(2, 3); step(3, 3);
        chk("R12 flags ignored", cnt_value, 5);
    endtask

    task automatic t_rings();
        evt_count = 0;
        set_cfg(0, 0, 0, 0, 1, 0, 1);
        load_cnt(0);
        step(5, 0); step(5, 2);
        chk("R7 kernel only", cnt_value, 5);
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 0, 0, 1);
        load_cnt(0);
        step(4, 0);
        chk("R7 user blocks ring0", cnt_value, 0);
        step(6, 1); step(1, 3);
        chk("R7 user rings", cnt_value, 7);
    endtask

    task automatic t_default_rings();
        evt_count = 0;
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        load_cnt(0);
        step(1, 0); step(2, 3);
        chk("R8 both admitted", cnt_value, 3);
    endtask

    task automatic t_disable();
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 1, 0, 0);
        load_cnt(40);
        step(9, 0); step(9, 2);
        chk("R9 hold while off", cnt_value, 40);
        evt_count = 0;
        set_cfg(1, 0, 1, 1, 1, 0, 1);
        load_cnt(0);
        step(1, 0); step(1, 0);
        chk("R9 edge first", cnt_value, 1);
        evt_count = 1;
        set_cfg(1, 0, 1, 1, 1, 0, 0);
        step(1, 0);
        chk("R9 off with edge", cnt_value, 1);
        set_cfg(1, 0, 1, 1, 1, 0, 1);
        step(1, 0); step(1, 0);
        chk("R9 resume counts once", cnt_value, 2);
    endtask

    task automatic t_write_priority();
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 1, 0, 1);
        evt_count = 7;
        load_cnt(100);
        chk("R10 write wins", cnt_value, 100);
        step(2, 0);
        chk("R10 counts after", cnt_value, 102);
    endtask

    task automatic t_wrap();
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 1, 1, 1);
        load_cnt({CNT_W{1'b1}} - 48'd2);
        step(5, 0);
        chk("R11 wrap value", cnt_value, 2);
        chk("R11 status set", {47'd0, ovf_status}, 1);
        chk("R11 irq set", {47'd0, irq}, 1);
        step(0, 0);
        chk("R11 sticky", {47'd0, irq}, 1);
        ovf_clr = 1'b1;
        tick();
        ovf_clr = 1'b0;
        chk("R11 cleared", {47'd0, ovf_status}, 0);
        evt_count = 0;
        set_cfg(0, 0, 0, 1, 1, 0, 1);
        load_cnt({CNT_W{1'b1}});
        step(1, 0);
        chk("R11 wrap no irq value", cnt_value, 0);
        chk("R11 no status", {47'd0, ovf_status}, 0);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 0; cfg_wdata = '0; evt_count = 0;
        priv_level = 0; cnt_we = 0; cnt_wdata = '0; ovf_clr = 0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", cnt_value, 0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_raw();
        t_thresh();
        t_invert();
        t_edge();
        t_no_thresh_flags();
        t_rings();
        t_default_rings();
        t_disable();
        t_write_priority();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule